// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flagged Character Queue

This block is one asynchronous serial receive channel. It runs from the system clock and samples the line only on a free-running enable pulse, `tick16`, that fires sixteen times per bit period. The serial input first passes through a synchroniser. A frame state machine then validates the start bit, takes the data bits least significant first, and checks the optional parity bit and the stop bit. It also recognises a line held low for a whole frame as a break.

Every completed character is queued in an eight-deep first-in first-out store. Three flags travel with it: break, framing error and parity error. The host sees the oldest character and its flags on the read outputs and removes it with a one-cycle `pop`. Two sticky bits complete the status: one reports an overrun and one reports a change of break. A one-cycle `err_clr` command clears both.

Character length and parity mode are static configuration inputs. They may change only while the line is idle.

Top module: `uart_rx_fifo`

## Requirements
- R1: A frame begins when the synchronised line is seen low on a tick. The line is sampled again on the 7th following tick. If it is high then, the start is dropped, no character is stored, and the search for a start bit resumes.
- R2: After a valid start, each data bit is sampled once every 16 ticks, first bit least significant. With a correct stop (high) and no parity error, the character is stored with all three flags clear.
- R3: `cfg_len` selects 5, 6, 7 or 8 data bits for the values 0, 1, 2 and 3. The stored byte holds the received bits right-aligned, and its unused upper bits are zero.
- R4: With `cfg_par_en` high, one parity bit follows the data. With `cfg_par_odd` low (even parity), the expected parity bit equals the XOR of the data bits. With `cfg_par_odd` high, it is the inverse. A mismatch sets the parity flag of that character only.
- R5: A low stop sample in a frame that had at least one high data or parity bit stores the character with its framing flag set. If the line is still low 8 ticks after that stop sample, that tick counts as a new start detection.
- R6: A frame that is low throughout (data, parity and stop) stores a zero byte with break=1, framing=0 and parity=0. It also sets `brk_chg`, which stays set until `err_clr`.
- R7: After a break, start search resumes only after the synchronised line has been high on two consecutive clock edges. A shorter high pulse followed by low starts nothing.
- R8: The queue holds 8 entries. `rdy` is high while at least one entry is present, and `full` is high while 8 are present. `pop` removes the head entry together with its flags. A `pop` while empty has no effect.
- R9: A character completed while the queue is full is held and is moved in as soon as space appears. If another start is validated while it is still held: `ovr` is set, the held character is discarded, and the queue contents stay unchanged. `err_clr` clears `ovr`.
- R10: The serial input passes through a two-flop synchroniser. After reset, `rdy`, `full`, `ovr` and `brk_chg` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | LEN_W | Character length code: length = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| pop | input | 1 | Remove head entry |
| err_clr | input | 1 | Clear `ovr` and `brk_chg` |
| rd_data | output | DATA_W | Head character |
| rd_brk | output | 1 | Head entry break flag |
| rd_ferr | output | 1 | Head entry framing flag |
| rd_perr | output | 1 | Head entry parity flag |
| rdy | output | 1 | Queue not empty |
| full | output | 1 | Queue holds DEPTH entries |
| ovr | output | 1 | Sticky overrun |
| brk_chg | output | 1 | Sticky break seen |

## Verification
The bound checker watches every cycle for the following:
- a rising overrun without a full queue the cycle before;
- a full queue losing an entry without a pop;
- a head entry flagged as break that holds a non-zero byte;
- sticky status dropping without a clear, or surviving one.

Bit timing, length masking, parity sense, the half-bit re-arm after a framing error, the two-edge high needed after a break, and the choice of which character an overrun discards only show up in the bench's scenarios. Those scenarios compare queue contents and occupancy against a behavioural queue model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_REARM,
      ST_BRK
   } rx_st_e;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rx_flags_t;

   localparam int FLAG_W = $bits(rx_flags_t);

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   initial begin
      assert (STAGES >= 2) else $error("rxf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst) sr <= '1;
      else     sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];

endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         not_empty,
   output logic         full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("rxf_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign do_push   = push && (count != CNT_MAX);
   assign do_pop    = pop && (count != '0);
   assign not_empty = (count != '0);
   assign full      = (count == CNT_MAX);
   assign dout      = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (do_push) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rxf_deser.sv
module rxf_deser
   import rxf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rx,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              fifo_full,
   input  logic              err_clr,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output rx_flags_t         push_flags,
   output logic              ovr,
   output logic              brk_chg
);

   localparam int CNT_W   = $clog2(OVS);
   localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
   localparam logic [CNT_W-1:0] C_START = CNT_W'(OVS / 2 - 2);
   localparam logic [CNT_W-1:0] C_HALF  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] C_BIT   = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   initial begin
      assert (OVS >= 4 && (OVS & (OVS - 1)) == 0)
         else $error("rxf_deser: OVS must be a power of two, at least 4");
      assert (MIN_LEN >= 1)
         else $error("rxf_deser: LEN_W too wide for DATA_W");
      assert ((1 << IDX_W) == DATA_W)
         else $error("rxf_deser: DATA_W must be a power of two");
   end

   rx_st_e            st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx, last_idx;
   logic [DATA_W-1:0] shreg, data_al;
   logic              par_bit, par_exp, any_high, hi_seen;
   logic              hold_vld;
   logic [DATA_W-1:0] hold_data;
   rx_flags_t         hold_flags;
   logic              perr_now;

   // Received bits enter at the top, so an n-bit character sits in the
   // upper n bits; shifting right aligns it and zero-fills the rest.
   always_comb begin
      last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_len);
      data_al  = shreg >> (TOP_IDX - last_idx);
      par_exp  = (^data_al) ^ cfg_par_odd;
      perr_now = cfg_par_en && (par_bit != par_exp);
   end

   assign push       = hold_vld && !fifo_full;
   assign push_data  = hold_data;
   assign push_flags = hold_flags;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         idx        <= '0;
         shreg      <= '0;
         par_bit    <= 1'b0;
         any_high   <= 1'b0;
         hi_seen    <= 1'b0;
         hold_vld   <= 1'b0;
         hold_data  <= '0;
         hold_flags <= '0;
         ovr        <= 1'b0;
         brk_chg    <= 1'b0;
      end else begin
         if (push) hold_vld <= 1'b0;

         case (st)
            ST_IDLE: begin
               if (tick && !rx) begin
                  st  <= ST_START;
                  cnt <= '0;
               end
            end

            ST_START: begin
               if (tick) begin
                  if (cnt == C_START) begin
                     cnt <= '0;
                     if (rx) begin
                        st <= ST_IDLE;
                     end else begin
                        st       <= ST_DATA;
                        idx      <= '0;
                        shreg    <= '0;
                        any_high <= 1'b0;
                        par_bit  <= 1'b0;
                        if (hold_vld && fifo_full) begin
                           ovr      <= 1'b1;
                           hold_vld <= 1'b0;
                        end
                     end
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end

            ST_DATA: begin
               if (tick) begin
                  if (cnt == C_BIT) begin
                     cnt      <= '0;
                     shreg    <= {rx, shreg[DATA_W-1:1]};
                     any_high <= any_high | rx;
                     idx      <= idx + IDX_W'(1);
                     if (idx == last_idx) st <= cfg_par_en ? ST_PAR : ST_STOP;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end

            ST_PAR: begin
               if (tick) begin
                  if (cnt == C_BIT) begin
                     cnt      <= '0;
                     par_bit  <= rx;
                     any_high <= any_high | rx;
                     st       <= ST_STOP;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end

            ST_STOP: begin
               if (tick) begin
                  if (cnt == C_BIT) begin
                     cnt      <= '0;
                     hold_vld <= 1'b1;
                     if (rx) begin
                        hold_data  <= data_al;
                        hold_flags <= '{brk: 1'b0, ferr: 1'b0, perr: perr_now};
                        st         <= ST_IDLE;
                     end else if (!any_high) begin
                        hold_data  <= '0;
                        hold_flags <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0};
                        brk_chg    <= 1'b1;
                        hi_seen    <= 1'b0;
                        st         <= ST_BRK;
                     end else begin
                        hold_data  <= data_al;
                        hold_flags <= '{brk: 1'b0, ferr: 1'b1, perr: perr_now};
                        st         <= ST_REARM;
                     end
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end

            ST_REARM: begin
               if (tick) begin
                  if (cnt == C_HALF) begin
                     cnt <= '0;
                     st  <= rx ? ST_IDLE : ST_START;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end

            ST_BRK: begin
               if (rx) begin
                  if (hi_seen) st <= ST_IDLE;
                  hi_seen <= 1'b1;
               end else begin
                  hi_seen <= 1'b0;
               end
            end

            default: st <= ST_IDLE;
         endcase

         if (err_clr) begin
            ovr     <= 1'b0;
            brk_chg <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import rxf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 8,
   parameter int OVS         = 16,
   parameter int LEN_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick16,
   input  logic              rxd,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              pop,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_brk,
   output logic              rd_ferr,
   output logic              rd_perr,
   output logic              rdy,
   output logic              full,
   output logic              ovr,
   output logic              brk_chg
);

   localparam int ENT_W = FLAG_W + DATA_W;

   logic              rx_s;
   logic              q_push;
   logic [DATA_W-1:0] q_data;
   rx_flags_t         q_flags, head_flags;
   logic [ENT_W-1:0]  head;

   // A zero stage count selects a bypass for inputs already in this domain.
   if (SYNC_STAGES > 0) begin : g_sync
      rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk (clk),
         .rst (rst),
         .d   (rxd),
         .q   (rx_s)
      );
   end else begin : g_nosync
      assign rx_s = rxd;
   end

   rxf_deser #(
      .DATA_W (DATA_W),
      .OVS    (OVS),
      .LEN_W  (LEN_W)
   ) u_deser (
      .clk         (clk),
      .rst         (rst),
      .tick        (tick16),
      .rx          (rx_s),
      .cfg_len     (cfg_len),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .fifo_full   (full),
      .err_clr     (err_clr),
      .push        (q_push),
      .push_data   (q_data),
      .push_flags  (q_flags),
      .ovr         (ovr),
      .brk_chg     (brk_chg)
   );

   rxf_fifo #(
      .W     (ENT_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (q_push),
      .din       ({q_flags, q_data}),
      .pop       (pop),
      .dout      (head),
      .not_empty (rdy),
      .full      (full)
   );

   assign head_flags = rx_flags_t'(head[ENT_W-1:DATA_W]);
   assign rd_data    = head[DATA_W-1:0];
   assign rd_brk     = head_flags.brk;
   assign rd_ferr    = head_flags.ferr;
   assign rd_perr    = head_flags.perr;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              pop,
   input logic              err_clr,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_brk,
   input logic              rdy,
   input logic              full,
   input logic              ovr,
   input logic              brk_chg
);

   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
      $rose(ovr) |-> $past(full));                                   // R9

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
      ovr && !err_clr |=> ovr);                                      // R9

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
      err_clr |=> !ovr && !brk_chg);                                 // R6

   AST_BRKCHG_STICKY: assert property (@(posedge clk) disable iff (rst)
      brk_chg && !err_clr |=> brk_chg);                              // R6

   AST_BRK_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
      rdy && rd_brk |-> rd_data == '0);                              // R6

   AST_FULL_KEPT: assert property (@(posedge clk) disable iff (rst)
      full && !pop |=> full);                                        // R8

   AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
      full |-> rdy);                                                 // R8

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .pop     (pop),
   .err_clr (err_clr),
   .rd_data (rd_data),
   .rd_brk  (rd_brk),
   .rdy     (rdy),
   .full    (full),
   .ovr     (ovr),
   .brk_chg (brk_chg)
);

// File: tb/uart_rx_fifo_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       pop = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] rd_data;
   logic       rd_brk, rd_ferr, rd_perr, rdy, full, ovr, brk_chg;

   int checks = 0;
   int errors = 0;
   int tdiv = 0;
   logic finished = 1'b0;

   // Model queue entry: {brk, ferr, perr, data[7:0]}
   logic [10:0] mq[$];
   logic        cmp_en = 1'b0;
   logic        cmp_bad = 1'b0;
   logic        cmp_rdy, cmp_full;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tick16 <= (tdiv == 3);
      tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
   end

   uart_rx_fifo u_uart_rx_fifo (
      .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .pop(pop), .err_clr(err_clr),
      .rd_data(rd_data), .rd_brk(rd_brk), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
      .rdy(rdy), .full(full), .ovr(ovr), .brk_chg(brk_chg)
   );

   // Occupancy compared with the model on every clock of a settle window.
   always @(negedge clk) begin
      if (cmp_en && !cmp_bad) begin
         if (rdy !== (mq.size() > 0) || full !== (mq.size() >= 8)) begin
            cmp_bad  = 1'b1;
            cmp_rdy  = rdy;
            cmp_full = full;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!tick16) @(posedge clk);
      end
   endtask

   task automatic drive_bit(input logic v);
      @(negedge clk);
      rxd = v;
      wait_ticks(16);
   endtask

   task automatic send_char(input logic [7:0] d, input logic stopv, input logic badpar);
      int   n;
      logic pb;
      n  = 5 + int'(cfg_len);
      pb = 1'b0;
      wait_ticks(1);
      drive_bit(1'b0);
      for (int i = 0; i < n; i++) begin
         drive_bit(d[i]);
         pb = pb ^ d[i];
      end
      if (cfg_par_en) drive_bit(pb ^ cfg_par_odd ^ badpar);
      drive_bit(stopv);
   endtask

   task automatic expect_entry(input logic [7:0] d, input logic b, input logic f, input logic p);
      mq.push_back({b, f, p, d});
   endtask

   task automatic settle(input string tag);
      cmp_bad = 1'b0;
      cmp_en  = 1'b1;
      repeat (30) @(negedge clk);
      cmp_en = 1'b0;
      checks++;
      if (cmp_bad) begin
         errors++;
         $display("FAIL %s occupancy actual rdy=%0b full=%0b expected rdy=%0b full=%0b",
                  tag, cmp_rdy, cmp_full, mq.size() > 0, mq.size() >= 8);
      end
   endtask

   task automatic pop_check(input string tag);
      logic [10:0] act, exp;
      @(negedge clk);
      checks++;
      act = {rd_brk, rd_ferr, rd_perr, rd_data};
      if (mq.size() == 0) begin
         errors++;
         $display("FAIL %s pop with empty model actual=%0h expected=none", tag, act);
      end else begin
         exp = mq.pop_front();
         if (act !== exp || rdy !== 1'b1) begin
            errors++;
            $display("FAIL %s entry actual=%0h rdy=%0b expected=%0h rdy=1", tag, act, rdy, exp);
         end
      end
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_clr;
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (6) @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // R10: reset state
      chk("R10 rdy after reset", int'(rdy), 0);
      chk("R10 full after reset", int'(full), 0);
      chk("R10 ovr after reset", int'(ovr), 0);
      chk("R10 brk_chg after reset", int'(brk_chg), 0);

      // R8: pop on empty ignored, then an 8-bit character (R2)
      @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0;
      send_char(8'hA5, 1'b1, 1'b0);
      expect_entry(8'hA5, 0, 0, 0);
      settle("R8 empty pop ignored");
      chk("R8 rdy with one entry", int'(rdy), 1);
      pop_check("R2 8-bit A5");

      // R1: short low pulse is rejected
      wait_ticks(1);
      @(negedge clk); rxd = 1'b0;
      wait_ticks(3);
      @(negedge clk); rxd = 1'b1;
      wait_ticks(40);
      settle("R1 glitch rejected");
      send_char(8'h3C, 1'b1, 1'b0);
      expect_entry(8'h3C, 0, 0, 0);
      settle("R1 after glitch");
      pop_check("R2 8-bit 3C after glitch R1");

      // R3 / R4: 5-bit even parity, bad parity, 7-bit odd parity
      cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      send_char(8'hFF, 1'b1, 1'b0);
      expect_entry(8'h1F, 0, 0, 0);
      send_char(8'h17, 1'b1, 1'b1);
      expect_entry(8'h17, 0, 0, 1);
      cfg_len = 2'd2; cfg_par_odd = 1'b1;
      send_char(8'hD5, 1'b1, 1'b0);
      expect_entry(8'h55, 0, 0, 0);
      send_char(8'h0E, 1'b1, 1'b1);
      expect_entry(8'h0E, 0, 0, 1);
      settle("R3 short characters");
      pop_check("R3 5-bit upper bits zero");
      pop_check("R4 even parity mismatch");
      pop_check("R3 7-bit odd parity ok R4");
      pop_check("R4 odd parity mismatch");
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

      // R5: framing error, line stays low -> next start at half bit
      send_char(8'h81, 1'b0, 1'b0);
      expect_entry(8'h81, 0, 1, 0);
      send_char(8'h42, 1'b1, 1'b0);
      expect_entry(8'h42, 0, 0, 0);
      settle("R5 rearm pair");
      pop_check("R5 framing flag");
      pop_check("R5 character after rearm");

      // R5: framing error with line returning high
      send_char(8'h07, 1'b0, 1'b0);
      @(negedge clk); rxd = 1'b1;
      wait_ticks(40);
      expect_entry(8'h07, 0, 1, 0);
      settle("R5 framing then idle");
      pop_check("R5 single framing entry");

      // R6: break
      wait_ticks(1);
      @(negedge clk); rxd = 1'b0;
      wait_ticks(176);
      @(negedge clk); rxd = 1'b1;
      wait_ticks(4);
      expect_entry(8'h00, 1, 0, 0);
      settle("R6 break stored");
      chk("R6 brk_chg set", int'(brk_chg), 1);
      pop_check("R6 break entry");
      chk("R6 brk_chg sticky after pop", int'(brk_chg), 1);
      pulse_clr();
      chk("R6 brk_chg cleared", int'(brk_chg), 0);

      // R7: one-clock high after break does not re-arm
      wait_ticks(1);
      @(negedge clk); rxd = 1'b0;
      wait_ticks(176);
      @(negedge clk); rxd = 1'b1;
      @(negedge clk); rxd = 1'b0;
      wait_ticks(48);
      @(negedge clk); rxd = 1'b1;
      wait_ticks(4);
      expect_entry(8'h00, 1, 0, 0);
      send_char(8'h66, 1'b1, 1'b0);
      expect_entry(8'h66, 0, 0, 0);
      settle("R7 rearm after break");
      pop_check("R7 break entry");
      pop_check("R7 first character after break");
      pulse_clr();

      // R8 / R9: fill, hold, overrun
      for (int k = 0; k < 8; k++) begin
         send_char(8'h10 + 8'(k), 1'b1, 1'b0);
         expect_entry(8'h10 + 8'(k), 0, 0, 0);
      end
      settle("R8 eight entries");
      chk("R8 full at eight", int'(full), 1);
      send_char(8'h18, 1'b1, 1'b0);
      expect_entry(8'h18, 0, 0, 0);
      settle("R9 held character");
      chk("R9 no overrun while held", int'(ovr), 0);
      send_char(8'h19, 1'b1, 1'b0);
      void'(mq.pop_back());
      expect_entry(8'h19, 0, 0, 0);
      settle("R9 after overrun");
      chk("R9 overrun set", int'(ovr), 1);
      for (int k = 0; k < 9; k++) pop_check("R9 queue order");
      settle("R8 drained");
      chk("R9 ovr sticky", int'(ovr), 1);
      pulse_clr();
      chk("R9 ovr cleared", int'(ovr), 0);

      finished = 1'b1;
      finish_run();
   end

endmodule